// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM that stores 8-bit bytes at 19-bit addresses. The host hands over one byte-wide read or write at a time through a valid/ready request port. The sequencer then produces the chip-select, write-strobe and output-enable levels, the address, and the outgoing data with its driver enable. These levels are arranged so that every asynchronous minimum of the memory holds. Read bytes come back on a one-cycle response pulse.

All memory minimums are given in nanoseconds as parameters. Each one is rounded up to a whole number of clock cycles from the clock-period parameter. Every access has the same shape:

- One setup cycle in which the new address is presented with all strobes inactive.
- An access window with the strobes active.
- A release window with the strobes inactive again.

The outgoing data driver is kept off until the memory's own outputs have had time to let go of the shared bus. It is dropped on the same edge that ends the write. The bidirectional pin itself is outside this block, which gives a data-out, a driver enable and a data-in.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: Before chip select falls for a new access, mem_ce_n, mem_we_n and mem_oe_n have all been 1 for at least one full cycle.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CYC cycles. RD_CYC is the largest of ceil(T_CYCLE_NS/CLK_NS), ceil(T_ACC_NS/CLK_NS) and ceil(T_OEA_NS/CLK_NS), which is 3 at the defaults. mem_dq_in is sampled on the edge that ends this window.
- R4: A read's rsp_valid is high for exactly one cycle, beginning 1+RD_CYC edges after the accepting edge. rsp_rdata carries the sampled byte.
- R5: A write holds mem_ce_n=0 and mem_we_n=0 together for WR_CYC cycles, with mem_oe_n=1 throughout. WR_CYC is the largest of the cycle-time, write-pulse and chip-select-to-end cycle counts and TA_CYC+ceil(T_DS_NS/CLK_NS), which is 3 at the defaults.
- R6: mem_dq_oe rises only after mem_we_n has been 0 for TA_CYC=max(1,ceil(T_HZ_NS/CLK_NS)) cycles. It falls on the same edge that mem_we_n returns to 1, and it is never 1 unless mem_ce_n=0, mem_we_n=0 and mem_oe_n=1.
- R7: mem_addr changes only on an edge where mem_ce_n and mem_we_n are 1 both before and after the edge. mem_addr and mem_dq_out stay constant for the whole access.
- R8: req_ready is 1 only while idle, and a request is taken on an edge where req_valid and req_ready are both 1. With requests waiting, consecutive accepting edges are 2+ACC+REL_CYC apart, where ACC is RD_CYC or WR_CYC of the earlier access and REL_CYC=max(1,ceil(T_HZ_NS/CLK_NS)).
- R9: A read returns the byte most recently written to that address.
- R10: mem_oe_n and mem_we_n are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Byte read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the host-side data driver |
| mem_dq_in | input | DATA_W | Data from the memory pins |

## Verification
The in-RTL properties check the following on every cycle:
- The write and output strobes are never active together.
- The data driver is confined to the write strobe's active window, does not start in the strobe's first cycle, and is off when the strobe rises.
- The address moves only with both strobes inactive.
- Write data stays put while writing.
- The response is a single-cycle pulse.
- The interface is quiet after reset.

Only the bench's timed memory model can show the nanosecond minimums: write pulse width, chip-select and address-to-end times, data setup, driver turnaround after the memory releases the bus, and read access time. The same holds for response latency, accept-to-accept spacing and correct contents across random read/write mixes.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACCESS  = 2'd2,
    ST_RELEASE = 2'd3
  } seq_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 3,
  parameter int WR_CYC  = 3,
  parameter int TA_CYC  = 1,
  parameter int REL_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_write,
  output logic ready,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  localparam int MAXC  = imax(imax(RD_CYC, WR_CYC), REL_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;
  logic             last_acc;
  logic             last_rel;

  assign last_acc = wr_q ? (cnt == CNT_W'(WR_CYC - 1)) : (cnt == CNT_W'(RD_CYC - 1));
  assign last_rel = (cnt == CNT_W'(REL_CYC - 1));
  assign ready    = (st == ST_IDLE) && !rst;
  assign capture  = (st == ST_ACCESS) && !wr_q && last_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            st   <= ST_SETUP;
            wr_q <= is_write;
          end
        end
        ST_SETUP: begin
          st   <= ST_ACCESS;
          cnt  <= '0;
          ce_n <= 1'b0;
          we_n <= !wr_q;
          oe_n <= wr_q;
        end
        ST_ACCESS: begin
          cnt <= cnt + 1'b1;
          if (wr_q && cnt == CNT_W'(TA_CYC - 1))
            dq_oe <= 1'b1;
          if (last_acc) begin
            st    <= ST_RELEASE;
            cnt   <= '0;
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (last_rel) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end
        end
      endcase
    end
  end

  // R1: quiet interface after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (ce_n && we_n && oe_n && !dq_oe));

  // R10: never both strobes active
  a_r10_oe_we_excl: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  // R6: driver only inside a write window
  a_r6_drv_window: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!ce_n && !we_n && oe_n));

  // R6: driver off in the first strobe cycle and when the strobe rises
  a_r6_drv_late: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> !dq_oe);
  a_r6_drv_release: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> !dq_oe);

  // R3: read window shape
  a_r3_read_shape: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> (!ce_n && we_n));

  // R5: write window shape
  a_r5_write_shape: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (!ce_n && oe_n));

  // R8: ready only with the memory idle
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ce_n && we_n && oe_n && !dq_oe));

  // R2: chip select falls only after a cycle with all strobes inactive
  a_r2_standby_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(ce_n) |-> ($past(we_n) && $past(oe_n)));

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              ce_n,
  input  logic              we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (start) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rsp_valid <= capture;
      if (capture)
        rsp_rdata <= mem_dq_in;
    end
  end

  // R7: address moves only with both strobes inactive on both sides of the edge
  a_r7_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> (ce_n && we_n && $past(ce_n) && $past(we_n)));

  // R7: write data held while the write strobe stays active
  a_r7_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> $stable(mem_dq_out));

  // R4: response is a single-cycle pulse
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 20,
  parameter int T_CYCLE_NS = 55,
  parameter int T_ACC_NS   = 55,
  parameter int T_OEA_NS   = 30,
  parameter int T_WP_NS    = 45,
  parameter int T_CW_NS    = 50,
  parameter int T_DS_NS    = 25,
  parameter int T_HZ_NS    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC  = imax(ns_to_cyc(T_CYCLE_NS, CLK_NS),
                                imax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OEA_NS, CLK_NS)));
  localparam int TA_CYC  = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int WR_CYC  = imax(imax(ns_to_cyc(T_CYCLE_NS, CLK_NS), ns_to_cyc(T_WP_NS, CLK_NS)),
                                imax(ns_to_cyc(T_CW_NS, CLK_NS), TA_CYC + ns_to_cyc(T_DS_NS, CLK_NS)));
  localparam int REL_CYC = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));

  logic start;
  logic capture;

  assign start = req_valid && req_ready;

  asram_seq #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .TA_CYC (TA_CYC),
    .REL_CYC(REL_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .is_write(req_write),
    .ready   (req_ready),
    .capture (capture),
    .ce_n    (mem_ce_n),
    .we_n    (mem_we_n),
    .oe_n    (mem_oe_n),
    .dq_oe   (mem_dq_oe)
  );

  asram_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .mem_dq_in (mem_dq_in),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int AW     = 19;
  localparam int DW     = 8;
  localparam int CLK_NS = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected cycle counts from the requirements
  localparam int E_TA  = 1;
  function automatic int exp_rd();  return mx(cdiv(55), mx(cdiv(55), cdiv(30))); endfunction
  function automatic int exp_ta();  return mx(1, cdiv(20)); endfunction
  function automatic int exp_wr();  return mx(mx(cdiv(55), cdiv(45)), mx(cdiv(50), exp_ta() + cdiv(25))); endfunction
  function automatic int exp_rel(); return mx(1, cdiv(20)); endfunction

  function automatic logic [7:0] init_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h3C;
  endfunction

  // ---------------- timed memory model ----------------
  logic [7:0] marr [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] mget(input logic [AW-1:0] a);
    return marr.exists(int'(a)) ? marr[int'(a)] : init_byte(a);
  endfunction
  function automatic logic [7:0] rget(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_byte(a);
  endfunction

  logic          p_ce, p_we, p_oe, p_oe_drv, p_drv;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dout;
  longint now, t_ce_fall, t_ce_rise, t_we_fall, t_oe_fall, t_addr, t_data, t_mem_off, nxt;
  logic   drv_now, valid_rd;

  always begin
    @(posedge clk);
    #1;
    now = $time - 1;
    drv_now = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (rst) begin
      t_ce_fall = now; t_ce_rise = now; t_we_fall = now; t_oe_fall = now;
      t_addr = now; t_data = now; t_mem_off = 0;
      mem_dq_in = '0;
    end else begin
      if (mem_addr != p_addr) begin
        chk(mem_ce_n && mem_we_n && p_ce && p_we, "R7 address change with strobes inactive",
            {mem_ce_n, mem_we_n, p_ce, p_we}, 4'hF);
        t_addr = now;
      end
      chk(!(!mem_oe_n && !mem_we_n), "R10 strobes exclusive", {mem_oe_n, mem_we_n}, 2'b11);
      if (!mem_ce_n && p_ce) begin
        chk(p_we && p_oe && (now - t_ce_rise) >= CLK_NS, "R2 idle gap before select",
            now - t_ce_rise, CLK_NS);
        t_ce_fall = now;
      end
      if (mem_ce_n && !p_ce) t_ce_rise = now;
      if (!mem_we_n && p_we) t_we_fall = now;
      if (!mem_oe_n && p_oe) t_oe_fall = now;
      // end of a write
      if (!p_ce && !p_we && (mem_ce_n || mem_we_n)) begin
        chk(now - t_we_fall >= 45, "R5 write pulse width", now - t_we_fall, 45);
        chk(now - t_ce_fall >= 50, "R5 select to end of write", now - t_ce_fall, 50);
        chk(now - t_addr >= 50, "R7 address valid to end of write", now - t_addr, 50);
        chk(p_oe_drv && now - t_data >= 25, "R6 data setup before end of write", now - t_data, 25);
        chk(!mem_dq_oe, "R6 driver released with write end", mem_dq_oe, 0);
        chk(p_oe, "R5 output enable high in write", p_oe, 1);
        marr[int'(p_addr)] = p_dout;
      end
      // end of a read window
      if (p_drv && mem_ce_n)
        chk(now - t_ce_fall >= 55, "R3 read cycle length", now - t_ce_fall, 55);
      if (p_drv && !drv_now) t_mem_off = now;
      if (mem_dq_oe && !p_oe_drv) begin
        chk(!mem_we_n && !mem_ce_n && (now - t_we_fall) >= 20 && (now - t_mem_off) >= 20,
            "R6 driver turnaround", now - t_we_fall, 20);
        t_data = now;
      end
      if (mem_dq_oe) begin
        chk(!drv_now, "R6 bus contention", drv_now, 0);
        if (p_oe_drv && mem_dq_out != p_dout) begin
          chk(1'b0, "R7 write data changed while driven", mem_dq_out, p_dout);
          t_data = now;
        end
      end
      if (drv_now) begin
        nxt = now + CLK_NS;
        valid_rd = (nxt - ((t_addr > t_ce_fall) ? t_addr : t_ce_fall) >= 55) && (nxt - t_oe_fall >= 30);
        mem_dq_in = valid_rd ? mget(mem_addr) : ~mget(mem_addr);
      end else begin
        mem_dq_in = 8'h00;
      end
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_oe_drv = mem_dq_oe;
    p_addr = mem_addr; p_dout = mem_dq_out; p_drv = drv_now;
  end

  // ---------------- host side ----------------
  longint last_acc = 0;
  int     prev_gap = 0;
  bit     have_prev = 1'b0;

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit b2b);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready low while busy", req_ready, 0);
    if (b2b && have_prev)
      chk((cyc - last_acc) == prev_gap, "R8 accept spacing", cyc - last_acc, prev_gap);
    last_acc  = cyc;
    have_prev = 1'b1;
    prev_gap  = 2 + (wr ? exp_wr() : exp_rd()) + exp_rel();
    if (wr) begin
      ref_mem[int'(a)] = d;
    end else begin
      for (int j = 0; j < 20 && !rsp_valid; j++) @(negedge clk);
      chk(rsp_valid && (cyc - last_acc) == 1 + exp_rd(), "R4 response latency",
          cyc - last_acc, 1 + exp_rd());
      chk(rsp_rdata == rget(a), "R9 read returns stored byte", rsp_rdata, rget(a));
      @(negedge clk);
      chk(!rsp_valid, "R4 response one cycle", rsp_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes inactive in reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe && !rsp_valid, "R1 driver and response off in reset",
        {mem_dq_oe, rsp_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset",
        {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

    // directed corners
    issue(1'b0, 19'h00123, 8'h00, 1'b0);   // R3 read of unwritten location
    issue(1'b1, 19'h00000, 8'hA7, 1'b1);   // R5 lowest address
    issue(1'b1, 19'h7FFFF, 8'h5E, 1'b1);   // R5 highest address
    issue(1'b0, 19'h00000, 8'h00, 1'b1);   // R9 back-to-back write then read
    issue(1'b0, 19'h7FFFF, 8'h00, 1'b1);
    issue(1'b1, 19'h7FFFF, 8'hFF, 1'b1);   // R9 overwrite
    issue(1'b1, 19'h7FFFF, 8'h01, 1'b1);
    issue(1'b0, 19'h7FFFF, 8'h00, 1'b1);
    issue(1'b0, 19'h7FFFF, 8'h00, 1'b1);   // R3 read after read

    // random mix
    for (int i = 0; i < 200; i++) begin
      int gap;
      logic [AW-1:0] a;
      gap = $urandom % 4;
      a = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 48);
      if (gap > 1) repeat (gap) @(negedge clk);
      issue(($urandom % 2) == 1, a, DW'($urandom), gap <= 1);
    end

    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && req_ready, "R8 idle at end",
        {mem_ce_n, mem_we_n, mem_oe_n, req_ready}, 4'hF);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule